// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

This block is a byte-addressed controller for thirteen general-purpose pins. Each pin has two configuration bytes. The drive byte sets the direction, whether the pad is push-pull or open-drain, the pull enable and pull selection, and the level to drive. The sense byte reports the pin level after synchronization and selects which edges raise an event: none, falling, rising or both.

Each detected edge sets a sticky status bit. The thirteen status bits are split into two interrupt groups. Pins 0 to 6 form group 0, and pins 7 to 12 form group 1. Each group has a status byte that is cleared by writing 1 to a bit, and a mask byte. Every status bit that is pending and not masked drives one level-sensitive interrupt line.

Software writes a byte through a single-cycle write strobe. Reads are combinational and follow the address. The pull selection bits are stored and read back only. No resistor behaviour is modelled.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, every drive byte reads 0x00 (input, open-drain, no pull, level 0). Every sense byte has its edge mode at 00. Both status bytes read 0x00. Mask byte 0 reads 0x7F and mask byte 1 reads 0x3F. The irq output is 0 and no pin is driven.
- R2: The drive byte of pin p is at address p (0x00 to 0x0C). Bits 5:0 are written and read back. Bits 7:6 read as zero. The layout is bit 5 direction (1 = output), bit 4 drive type (1 = push-pull, 0 = open-drain), bit 3 pull enable, bits 2:1 pull select, and bit 0 output level.
- R3: A pin in input mode is never driven (pin_oe = 0). A push-pull output drives pin_out equal to the level bit with pin_oe = 1. An open-drain output drives 0 when the level is 0 and releases the pin (pin_oe = 0) when the level is 1.
- R4: The sense byte of pin p is at address 0x0D + p (0x0D to 0x19). Bit 0 reads the pin level after a two-stage synchronizer and cannot be written. Bits 2:1 are the writable edge mode. Bits 7:3 read as zero.
- R5: Edge mode 00 detects nothing, 01 detects falling edges, 10 detects rising edges, and 11 detects both. A qualifying edge sets the pin's status bit.
- R6: Status byte 0 is at 0x20 and status byte 1 is at 0x21. Mask byte 0 is at 0x22 and mask byte 1 is at 0x23. Pin p is in bit p of group 0 for p ≤ 6, and in bit p−7 of group 1 otherwise. Unused upper bits read as zero.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged, so one bit can be cleared while others stay pending.
- R8: When an edge and a clearing write land on the same status bit in the same cycle, the bit ends up set.
- R9: A status bit is set even while its mask bit is 1. The irq output is 1 exactly when some status bit is 1 and its mask bit is 0.
- R10: Addresses other than those in R2, R4 and R6 select nothing. Writing them changes no register, and reading them returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one byte per cycle |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pin_in | input | 13 | Pin levels seen at the pads |
| pin_out | output | 13 | Level driven onto each pad |
| pin_oe | output | 13 | Pad driver enable |
| irq | output | 1 | Level interrupt, unmasked pending events |

## Verification
A status bit can receive a new edge and a clearing write in the same clock cycle. The bench provokes this on pin 0 in both-edge mode with its status bit already set. It changes the pin level, counts the two synchronizer stages and the edge register, and raises the write strobe so that the write is sampled on the same edge that records the event. The bit is judged to be correct if it still reads as set afterwards, and a separate plain clear then shows that it does clear.

// File: rtl/gpio_edge_pkg.sv
`timescale 1ns/1ps
package gpio_edge_pkg;
    localparam int DATA_W = 8;

    // Drive byte layout, bits 5:0
    typedef struct packed {
        logic       dir;        // 1 = output
        logic       push_pull;  // 1 = push-pull, 0 = open-drain
        logic       pull_en;
        logic [1:0] pull_sel;
        logic       level;
    } pin_cfg_t;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_RISE = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;
endpackage

// File: rtl/gpio_sync2.sv
`timescale 1ns/1ps
module gpio_sync2 #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.meta   = async_in;
        s_d.stable = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_out = s_q.stable;
endmodule

// File: rtl/gpio_edge_detect.sv
`timescale 1ns/1ps
module gpio_edge_detect
    import gpio_edge_pkg::*;
#(
    parameter int N = 13
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   lvl,
    input  logic [2*N-1:0] mode,
    output logic [N-1:0]   evt
);
    logic [N-1:0] prev_d, prev_q;

    always_comb prev_d = lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar p = 0; p < N; p++) begin : g_pin
        edge_mode_e m;
        logic rise, fall;
        assign m    = edge_mode_e'(mode[2*p +: 2]);
        assign rise = lvl[p] & ~prev_q[p];
        assign fall = ~lvl[p] & prev_q[p];
        always_comb begin
            case (m)
                EDGE_FALL: evt[p] = fall;
                EDGE_RISE: evt[p] = rise;
                EDGE_BOTH: evt[p] = rise | fall;
                default:   evt[p] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_status.sv
`timescale 1ns/1ps
module gpio_status #(
    parameter int N = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] status
);
    logic [N-1:0] st_d, st_q;

    // a new event outranks a simultaneous clear
    always_comb st_d = (st_q & ~clr_vec) | set_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q;
endmodule

// File: rtl/gpio_pad_drv.sv
`timescale 1ns/1ps
module gpio_pad_drv
    import gpio_edge_pkg::*;
#(
    parameter int N = 13
) (
    input  pin_cfg_t [N-1:0] cfg,
    output logic [N-1:0]     pad_out,
    output logic [N-1:0]     pad_oe
);
    for (genvar p = 0; p < N; p++) begin : g_pad
        always_comb begin
            pad_out[p] = 1'b0;
            pad_oe[p]  = 1'b0;
            if (cfg[p].dir) begin
                if (cfg[p].push_pull) begin
                    pad_out[p] = cfg[p].level;
                    pad_oe[p]  = 1'b1;
                end else begin
                    pad_oe[p]  = ~cfg[p].level;
                end
            end
        end
    end
endmodule

// File: rtl/gpio_edge_ctrl.sv
`timescale 1ns/1ps
module gpio_edge_ctrl
    import gpio_edge_pkg::*;
#(
    parameter int NUM_PINS = 13,
    parameter int GRP0_W   = 7,
    parameter int ADDR_W   = 8,
    parameter int OUT_BASE = 'h00,
    parameter int IRQ_BASE = 'h20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);
    localparam int GRP1_W     = NUM_PINS - GRP0_W;
    localparam int IN_BASE    = OUT_BASE + NUM_PINS;
    localparam int STAT0_ADDR = IRQ_BASE;
    localparam int STAT1_ADDR = IRQ_BASE + 1;
    localparam int MASK0_ADDR = IRQ_BASE + 2;
    localparam int MASK1_ADDR = IRQ_BASE + 3;

    typedef struct packed {
        pin_cfg_t [NUM_PINS-1:0] ocfg;
        logic [2*NUM_PINS-1:0]   mode;
        logic [NUM_PINS-1:0]     mask;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic [NUM_PINS-1:0] sync_lvl, evt, stat_q, clr_vec, mask_vec, dir_vec;
    logic wr_stat0, wr_stat1;

    gpio_sync2 #(.W(NUM_PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(sync_lvl));

    gpio_edge_detect #(.N(NUM_PINS)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(sync_lvl), .mode(ctrl_q.mode), .evt(evt));

    gpio_status #(.N(NUM_PINS)) u_stat (
        .clk(clk), .rst_n(rst_n), .set_vec(evt), .clr_vec(clr_vec), .status(stat_q));

    gpio_pad_drv #(.N(NUM_PINS)) u_pad (
        .cfg(ctrl_q.ocfg), .pad_out(pin_out), .pad_oe(pin_oe));

    assign wr_stat0 = bus_we && (bus_addr == ADDR_W'(STAT0_ADDR));
    assign wr_stat1 = bus_we && (bus_addr == ADDR_W'(STAT1_ADDR));

    always_comb begin
        clr_vec = '0;
        if (wr_stat0) clr_vec[GRP0_W-1:0]        = bus_wdata[GRP0_W-1:0];
        if (wr_stat1) clr_vec[NUM_PINS-1:GRP0_W] = bus_wdata[GRP1_W-1:0];
    end

    // next-state of the configuration registers
    always_comb begin
        ctrl_d = ctrl_q;
        if (bus_we) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (bus_addr == ADDR_W'(OUT_BASE + p))
                    ctrl_d.ocfg[p] = pin_cfg_t'(bus_wdata[5:0]);
                if (bus_addr == ADDR_W'(IN_BASE + p))
                    ctrl_d.mode[2*p +: 2] = bus_wdata[2:1];
            end
            if (bus_addr == ADDR_W'(MASK0_ADDR))
                ctrl_d.mask[GRP0_W-1:0] = bus_wdata[GRP0_W-1:0];
            if (bus_addr == ADDR_W'(MASK1_ADDR))
                ctrl_d.mask[NUM_PINS-1:GRP0_W] = bus_wdata[GRP1_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q.ocfg <= '0;
            ctrl_q.mode <= '0;
            ctrl_q.mask <= '1;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (bus_addr == ADDR_W'(OUT_BASE + p))
                bus_rdata = DATA_W'(ctrl_q.ocfg[p]);
            if (bus_addr == ADDR_W'(IN_BASE + p))
                bus_rdata = DATA_W'({ctrl_q.mode[2*p +: 2], sync_lvl[p]});
        end
        if (bus_addr == ADDR_W'(STAT0_ADDR)) bus_rdata = DATA_W'(stat_q[GRP0_W-1:0]);
        if (bus_addr == ADDR_W'(STAT1_ADDR)) bus_rdata = DATA_W'(stat_q[NUM_PINS-1:GRP0_W]);
        if (bus_addr == ADDR_W'(MASK0_ADDR)) bus_rdata = DATA_W'(ctrl_q.mask[GRP0_W-1:0]);
        if (bus_addr == ADDR_W'(MASK1_ADDR)) bus_rdata = DATA_W'(ctrl_q.mask[NUM_PINS-1:GRP0_W]);
    end

    always_comb begin
        for (int p = 0; p < NUM_PINS; p++) dir_vec[p] = ctrl_q.ocfg[p].dir;
    end

    assign mask_vec = ctrl_q.mask;
    assign irq      = |(stat_q & ~mask_vec);
endmodule

// File: rtl/gpio_edge_chk.sv
`timescale 1ns/1ps
module gpio_edge_chk #(
    parameter int N          = 13,
    parameter int ADDR_W     = 8,
    parameter int STAT0_ADDR = 'h20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic [N-1:0]      status,
    input logic [N-1:0]      set_vec,
    input logic [N-1:0]      mask,
    input logic [N-1:0]      dir_vec,
    input logic [N-1:0]      pin_oe,
    input logic              irq
);
    assert_mask_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mask == '1));

    assert_input_undriven_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & ~dir_vec) == '0);

    assert_no_spurious_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(status) & ~$past(set_vec)) == '0));

    assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(STAT0_ADDR) && bus_wdata[0] && !set_vec[0])
        |=> !status[0]);

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((status & $past(set_vec)) == $past(set_vec)));

    assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '1) |-> !irq);
endmodule

bind gpio_edge_ctrl gpio_edge_chk #(
    .N(NUM_PINS), .ADDR_W(ADDR_W), .STAT0_ADDR(STAT0_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .status(stat_q), .set_vec(evt), .mask(mask_vec),
    .dir_vec(dir_vec), .pin_oe(pin_oe), .irq(irq)
);

// File: tb/sim_gpio_edge_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_edge_ctrl;
    localparam int N = 13;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_we = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [7:0]   bus_wdata = '0;
    logic [7:0]   bus_rdata;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] pin_out, pin_oe;
    logic         irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        int         kind;   // 0 rdata, 1 irq, 2 pin_oe bit, 3 pin_out bit
        int         idx;
        logic [7:0] exp;
        string      req;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;   // 125 MHz

    gpio_edge_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

    // monitor: compares queued expectations away from the rising edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = sb.pop_front();
            case (it.kind)
                0:       act = bus_rdata;
                1:       act = {7'd0, irq};
                2:       act = {7'd0, pin_oe[it.idx]};
                default: act = {7'd0, pin_out[it.idx]};
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s kind %0d idx %0d: actual 0x%02h expected 0x%02h",
                         it.req, it.kind, it.idx, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #2;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string req);
        @(posedge clk); #2;
        bus_addr = a;
        sb.push_back('{0, 0, e, req});
        @(negedge clk); #1;
    endtask

    task automatic look(input int kind, input int idx, input logic e, input string req);
        @(posedge clk); #2;
        sb.push_back('{kind, idx, {7'd0, e}, req});
        @(negedge clk); #1;
    endtask

    task automatic pin(input int p, input logic v);
        @(posedge clk); #2;
        pin_in[p] = v;
        repeat (4) @(posedge clk);
    endtask

    // pin edge and a write-1-to-clear land on the same clock edge
    task automatic pin_with_clear(input int p, input logic v,
                                  input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #2;
        pin_in[p] = v;
        @(posedge clk);
        @(posedge clk); #2;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        bus_we = 1'b0;
        repeat (2) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1 reset state
        rd(8'h00, 8'h00, "R1 drive byte");
        rd(8'h0D, 8'h00, "R1 sense byte");
        rd(8'h20, 8'h00, "R1 status0");
        rd(8'h21, 8'h00, "R1 status1");
        rd(8'h22, 8'h7F, "R1 mask0");
        rd(8'h23, 8'h3F, "R1 mask1");
        look(1, 0, 1'b0, "R1 irq");
        look(2, 4, 1'b0, "R1 pin_oe");

        // R2 drive byte readback
        wr(8'h03, 8'hFF);
        rd(8'h03, 8'h3F, "R2 upper bits zero");
        wr(8'h0C, 8'h2A);
        rd(8'h0C, 8'h2A, "R2 pin12");

        // R3 pad drive
        look(2, 3, 1'b1, "R3 push-pull oe");
        look(3, 3, 1'b1, "R3 push-pull out");
        wr(8'h03, 8'h20);
        look(2, 3, 1'b1, "R3 open-drain low oe");
        look(3, 3, 1'b0, "R3 open-drain low out");
        wr(8'h03, 8'h21);
        look(2, 3, 1'b0, "R3 open-drain release");
        wr(8'h05, 8'h11);
        look(2, 5, 1'b0, "R3 input undriven");

        // R4 sense byte
        pin(9, 1'b1);
        rd(8'h16, 8'h01, "R4 level");
        wr(8'h16, 8'hFF);
        rd(8'h16, 8'h07, "R4 mode bits");
        wr(8'h16, 8'h00);
        rd(8'h16, 8'h01, "R4 level not writable");

        // R5 edge modes on pin 2
        wr(8'h0F, 8'h04);
        pin(2, 1'b1); rd(8'h20, 8'h04, "R5 rising detected");
        wr(8'h20, 8'h04); rd(8'h20, 8'h00, "R5 cleared");
        pin(2, 1'b0); rd(8'h20, 8'h00, "R5 rising ignores fall");
        wr(8'h0F, 8'h02);
        pin(2, 1'b1); rd(8'h20, 8'h00, "R5 falling ignores rise");
        pin(2, 1'b0); rd(8'h20, 8'h04, "R5 falling detected");
        wr(8'h20, 8'h04);
        wr(8'h0F, 8'h06);
        pin(2, 1'b1); rd(8'h20, 8'h04, "R5 both rise");
        wr(8'h20, 8'h04);
        pin(2, 1'b0); rd(8'h20, 8'h04, "R5 both fall");
        wr(8'h20, 8'h04);
        wr(8'h0F, 8'h00);
        pin(2, 1'b1); rd(8'h20, 8'h00, "R5 disabled");
        rd(8'h0F, 8'h01, "R4 level pin2");

        // R6 / R9 group 1 and masking
        wr(8'h17, 8'h06);
        pin(10, 1'b1);
        rd(8'h21, 8'h08, "R6 pin10 in group1 bit3");
        look(1, 0, 1'b0, "R9 masked pending");
        wr(8'h23, 8'h00);
        look(1, 0, 1'b1, "R9 unmasked irq");
        rd(8'h23, 8'h00, "R6 mask1 write");
        wr(8'h23, 8'hFF);
        rd(8'h23, 8'h3F, "R6 mask1 upper zero");
        look(1, 0, 1'b0, "R9 remasked");
        wr(8'h23, 8'hF7);
        rd(8'h23, 8'h37, "R6 mask1 partial");
        look(1, 0, 1'b1, "R9 bit3 enabled");

        // R7 write-1-to-clear
        wr(8'h0D, 8'h06);
        wr(8'h0E, 8'h06);
        pin(0, 1'b1);
        pin(1, 1'b1);
        rd(8'h20, 8'h03, "R7 two pending");
        wr(8'h20, 8'h02); rd(8'h20, 8'h01, "R7 single clear");
        wr(8'h20, 8'h00); rd(8'h20, 8'h01, "R7 zero write keeps");
        wr(8'h21, 8'h00); rd(8'h21, 8'h08, "R7 group1 kept");
        wr(8'h20, 8'h01); rd(8'h20, 8'h00, "R7 cleared");
        wr(8'h21, 8'h08); rd(8'h21, 8'h00, "R7 group1 cleared");
        look(1, 0, 1'b0, "R9 irq drops");

        // R8 edge and clear together
        pin(0, 1'b0);
        rd(8'h20, 8'h01, "R8 primed");
        pin_with_clear(0, 1'b1, 8'h20, 8'h01);
        rd(8'h20, 8'h01, "R8 set wins");
        wr(8'h20, 8'h01);
        rd(8'h20, 8'h00, "R8 plain clear");

        // R10 unmapped addresses
        wr(8'h1A, 8'hFF);
        rd(8'h1A, 8'h00, "R10 unmapped read");
        rd(8'h00, 8'h00, "R10 pin0 drive untouched");
        rd(8'h19, 8'h00, "R10 pin12 sense untouched");
        wr(8'h24, 8'hFF);
        rd(8'h22, 8'h7F, "R10 mask0 untouched");
        rd(8'h23, 8'h37, "R10 mask1 untouched");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule